// File: doc/BRIEF.md
# Full-Duplex SPI Register Access Port

This block lets an external SPI host read and write a bank of 16-bit registers. The serial pins are brought into the system clock domain through two-flop synchronisers and edge detectors. The system clock must run at least four times faster than SCLK. Each frame carries exactly 16 SCLK cycles while chip select is low. The first bit of a frame says whether it is a write or a read. A write changes one byte of one register. A read fetches the whole 16-bit word, which is shifted out on the data output during the following frame. This is a full-duplex pipeline: while the host sends one command, it receives the answer to the one before.

The register bank sits outside the block. The port drives a one-cycle byte-write strobe with a register index, a byte-lane select and the data byte. For reads it presents a register index and captures the bank's combinational read word one cycle later. Bit 0 of the 6-bit byte address selects the byte lane: 1 is the upper byte and 0 is the lower byte. The register index is the address with bit 0 dropped.

The frame controller has four states:
- `ST_IDLE`: deselected. A synchronised chip-select fall moves it to `ST_SHIFT` and loads the transmit shifter.
- `ST_SHIFT`: counts and shifts SCLK rising edges. When chip select rises, a well-formed frame moves to `ST_COMMIT` and any other frame returns to `ST_IDLE`.
- `ST_COMMIT`: issues the write strobe and clears the pending read word. A write frame then returns to `ST_IDLE`; a read frame moves to `ST_FETCH`.
- `ST_FETCH`: captures the bank word as the pending read data, then returns to `ST_IDLE`.

The host must keep chip select high for at least four system clocks between frames.

Top module: `spi_regport`

## Requirements
- R1: While chip select is high, the output enable is low and the data output is 0. SCLK and DIN activity while deselected causes no write and leaves the pending read data unchanged.
- R2: DIN is sampled on SCLK rising edges, most significant bit first. Frame bit 15 is the direction flag (1 = write, 0 = read), bit 14 must be 0, bits 13:8 are the byte address and bits 7:0 are the data byte.
- R3: A well-formed write frame produces exactly one single-cycle write strobe, after chip select rises. The strobe carries index = address[5:1], upper-lane select = address[0] and the frame's data byte, so only one byte of the register changes.
- R4: A well-formed read frame through either the even or the odd address of a register makes the next frame shift out that register's full 16-bit value.
- R5: A read frame produces no write strobe, and its low 8 DIN bits have no effect.
- R6: The first frame after reset, and any frame following a well-formed write frame, shifts out all zeros.
- R7: Output data is MSB first. The first bit is valid a few system clocks after chip select falls, before the first SCLK rise. Each later bit changes only after an SCLK fall.
- R8: A frame is discarded if it has fewer or more than 16 SCLK rising edges, or if bit 14 is set. A discarded frame causes no write and leaves the pending read data unchanged.
- R9: Back-to-back read frames are pipelined: each frame returns the result of the read issued in the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn_i | input | 1 | Chip select from the pin, active low |
| spi_sclk_i | input | 1 | Serial clock from the pin |
| spi_mosi_i | input | 1 | Serial data in from the host |
| spi_miso_o | output | 1 | Serial data out to the host |
| spi_miso_oe_o | output | 1 | Tri-state enable for the data output pad |
| bank_wr_en_o | output | 1 | Single-cycle byte-write strobe |
| bank_wr_idx_o | output | 5 | Register index of the write |
| bank_wr_upper_o | output | 1 | 1 selects the upper byte, 0 the lower byte |
| bank_wr_byte_o | output | 8 | Byte to write |
| bank_rd_idx_o | output | 5 | Register index of the read |
| bank_rd_word_i | input | 16 | Combinational read word from the bank |

## Verification
A wrong bit counter or state shows up as a write strobe that is missing, doubled or misplaced. Such a fault is visible in the bank register and the strobe count within a few clocks of chip select rising. A corrupted pending word or transmit shifter is seen by the host one frame later, as a wrong output word: a zero where register data was due, a stale word after a discarded frame, or bits shifted by one position. An enable that lingers after deselection is visible at the pad within three system clocks of chip select rising.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 6;
    localparam int IDX_W      = ADDR_W - 1;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_FETCH  = 2'd3
    } frame_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          W        = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= pin_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/spi_edge_detect.sv
module spi_edge_detect #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise_i,
    input  logic              cs_fall_i,
    input  logic              sclk_rise_i,
    input  logic              din_i,
    output logic              frame_start_o,
    output logic              in_frame_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              upper_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              pend_clr_o,
    output logic              pend_load_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_BITS + 1);

    frame_state_t           state_q, state_d;
    logic [FRAME_BITS-1:0]  rx_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   frame_ok;
    logic                   is_write;

    assign frame_ok = (cnt_q == FULL_CNT) && !rx_q[FRAME_BITS-2];
    assign is_write = rx_q[FRAME_BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall_i) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise_i) state_d = frame_ok ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = is_write ? ST_IDLE : ST_FETCH;
            ST_FETCH:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (state_q == ST_IDLE && cs_fall_i) begin
            cnt_q <= '0;
        end else if (state_q == ST_SHIFT && sclk_rise_i && cnt_q != OVER_CNT) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q < FULL_CNT) rx_q <= {rx_q[FRAME_BITS-2:0], din_i};
        end
    end

    always_comb begin
        frame_start_o = (state_q == ST_IDLE) && cs_fall_i;
        in_frame_o    = (state_q == ST_SHIFT);
        wr_en_o       = (state_q == ST_COMMIT) && is_write;
        pend_clr_o    = (state_q == ST_COMMIT) && is_write;
        pend_load_o   = (state_q == ST_FETCH);
        idx_o         = rx_q[FRAME_BITS-3 -: IDX_W];
        upper_o       = rx_q[BYTE_W];
        byte_o        = rx_q[BYTE_W-1:0];
    end

    // R3: the write strobe lasts exactly one cycle
    p_wr_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R8: a frame with a bad edge count or bit 14 set returns to idle with no write
    p_discard_bad_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise_i && !frame_ok) |=> (state_q == ST_IDLE && !wr_en_o));

    // R4: the read word is captured only right after a read commit
    p_fetch_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_load_o |-> ($past(state_q) == ST_COMMIT && !$past(is_write)));

    // R5: a write and a fetch never coincide
    p_wr_fetch_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, pend_load_o}));
endmodule

// File: rtl/spi_tx_pipe.sv
module spi_tx_pipe
    import spi_regport_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start_i,
    input  logic                  in_frame_i,
    input  logic                  sclk_fall_i,
    input  logic                  pend_clr_i,
    input  logic                  pend_load_i,
    input  logic [FRAME_BITS-1:0] rd_word_i,
    output logic                  tx_bit_o
);
    logic [FRAME_BITS-1:0] pend_q;
    logic [FRAME_BITS-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pend_q <= '0;
        else if (pend_clr_i)  pend_q <= '0;
        else if (pend_load_i) pend_q <= rd_word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        shift_q <= '0;
        else if (frame_start_i)            shift_q <= pend_q;
        else if (in_frame_i && sclk_fall_i) shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
    end

    assign tx_bit_o = shift_q[FRAME_BITS-1];

    // R7: the output bit moves only on a frame start or an in-frame SCLK fall
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_i && !(in_frame_i && sclk_fall_i)) |=> $stable(tx_bit_o));

    // R8: the pending word changes only through a commit or a fetch
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_clr_i && !pend_load_i) |=> $stable(pend_q));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn_i,
    input  logic              spi_sclk_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o,
    output logic              bank_wr_en_o,
    output logic [IDX_W-1:0]  bank_wr_idx_o,
    output logic              bank_wr_upper_o,
    output logic [BYTE_W-1:0] bank_wr_byte_o,
    output logic [IDX_W-1:0]  bank_rd_idx_o,
    input  logic [FRAME_BITS-1:0] bank_rd_word_i
);
    // synchronised vector: [2] chip select, [1] serial clock, [0] data in
    logic [2:0] pins_sync;
    logic [1:0] edge_rise, edge_fall;
    logic       frame_start, in_frame, pend_clr, pend_load, tx_bit;
    logic [IDX_W-1:0] idx;

    spi_pin_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({spi_csn_i, spi_sclk_i, spi_mosi_i}),
        .sync_o (pins_sync)
    );

    // edge vector: [1] chip select, [0] serial clock
    spi_edge_detect #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pins_sync[2:1]),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    spi_frame_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_rise_i     (edge_rise[1]),
        .cs_fall_i     (edge_fall[1]),
        .sclk_rise_i   (edge_rise[0]),
        .din_i         (pins_sync[0]),
        .frame_start_o (frame_start),
        .in_frame_o    (in_frame),
        .wr_en_o       (bank_wr_en_o),
        .idx_o         (idx),
        .upper_o       (bank_wr_upper_o),
        .byte_o        (bank_wr_byte_o),
        .pend_clr_o    (pend_clr),
        .pend_load_o   (pend_load)
    );

    spi_tx_pipe u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .in_frame_i    (in_frame),
        .sclk_fall_i   (edge_fall[0]),
        .pend_clr_i    (pend_clr),
        .pend_load_i   (pend_load),
        .rd_word_i     (bank_rd_word_i),
        .tx_bit_o      (tx_bit)
    );

    assign bank_wr_idx_o = idx;
    assign bank_rd_idx_o = idx;
    assign spi_miso_oe_o = ~pins_sync[2];
    assign spi_miso_o    = spi_miso_oe_o & tx_bit;

    // R1: a chip select seen high two clocks ago keeps the pad disabled
    p_quiet_when_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_csn_i, 2) |-> (!spi_miso_oe_o && !spi_miso_o));

    // R3: writes are issued only after deselection
    p_wr_after_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_en_o |-> pins_sync[2]);
endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
    localparam int HALF = 4;
    localparam int GAP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, wr_en, wr_upper;
    logic [4:0]  wr_idx, rd_idx;
    logic [7:0]  wr_byte;
    logic [15:0] rd_word;

    logic [15:0] bank [32];
    logic [15:0] ref_q [32];
    logic [15:0] exp_pend;
    int          wr_count = 0;
    int          n_checks = 0;
    int          n_fail   = 0;

    always #2 clk = ~clk;

    spi_regport u_spi_regport (
        .clk             (clk),
        .rst_n           (rst_n),
        .spi_csn_i       (csn),
        .spi_sclk_i      (sclk),
        .spi_mosi_i      (mosi),
        .spi_miso_o      (miso),
        .spi_miso_oe_o   (miso_oe),
        .bank_wr_en_o    (wr_en),
        .bank_wr_idx_o   (wr_idx),
        .bank_wr_upper_o (wr_upper),
        .bank_wr_byte_o  (wr_byte),
        .bank_rd_idx_o   (rd_idx),
        .bank_rd_word_i  (rd_word)
    );

    assign rd_word = bank[rd_idx];

    always @(posedge clk) begin
        if (wr_en) begin
            wr_count <= wr_count + 1;
            if (wr_upper) bank[wr_idx][15:8] <= wr_byte;
            else          bank[wr_idx][7:0]  <= wr_byte;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] mk_write(input logic [5:0] addr, input logic [7:0] d);
        return {1'b1, 1'b0, addr, d};
    endfunction

    function automatic logic [15:0] mk_read(input logic [5:0] addr, input logic [7:0] junk);
        return {1'b0, 1'b0, addr, junk};
    endfunction

    function automatic logic [15:0] expect_bits(input logic [15:0] p, input int n);
        if (n >= 16) return p;
        return p >> (16 - n);
    endfunction

    task automatic run_frame(input logic [15:0] w, input int nclk, output logic [15:0] got, output logic oe_seen);
        got = '0;
        oe_seen = 1'b0;
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'($urandom);
            repeat (HALF) @(negedge clk);
            if (i < 16) got = {got[14:0], miso};
            if (i == 0) oe_seen = miso_oe;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic do_op(input logic [15:0] w, input int nclk);
        logic [15:0] got;
        logic        oe_seen;
        logic [15:0] pre;
        int          wc0;
        logic        valid;
        logic [4:0]  idx;
        pre = exp_pend;
        wc0 = wr_count;
        run_frame(w, nclk, got, oe_seen);
        idx = w[13:9];
        valid = (nclk == 16) && !w[14];
        // R4 R6 R9: output word equals the pending word from the frame before
        chk(got == expect_bits(pre, nclk), "R4/R6/R9 miso word", {16'h0, got}, {16'h0, expect_bits(pre, nclk)});
        chk(oe_seen == 1'b1, "R7 oe in frame", {31'h0, oe_seen}, 32'h1);
        chk(miso_oe == 1'b0 && miso == 1'b0, "R1 idle pad", {30'h0, miso_oe, miso}, 32'h0);
        if (valid && w[15]) begin
            if (w[8]) ref_q[idx][15:8] = w[7:0];
            else      ref_q[idx][7:0]  = w[7:0];
            exp_pend = '0;
            chk(wr_count == wc0 + 1, "R3 one strobe", wr_count, wc0 + 1);
            chk(bank[idx] == ref_q[idx], "R2/R3 byte write", {16'h0, bank[idx]}, {16'h0, ref_q[idx]});
        end else if (valid) begin
            exp_pend = ref_q[idx];
            chk(wr_count == wc0, "R5 read no strobe", wr_count, wc0);
        end else begin
            chk(wr_count == wc0, "R8 discard no strobe", wr_count, wc0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 32; k++) begin
            bank[k]  = 16'($urandom);
            ref_q[k] = bank[k];
        end
        exp_pend = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(miso_oe == 1'b0 && miso == 1'b0 && wr_en == 1'b0, "R1 reset state",
            {29'h0, miso_oe, miso, wr_en}, 32'h0);

        // R6: first frame after reset returns zeros; read reg 5 via odd address
        do_op(mk_read(6'd11, 8'hA5), 16);
        // R4: next frame returns full reg 5; read again via even address
        do_op(mk_read(6'd10, 8'h3C), 16);
        // R3: write upper then lower byte of reg 5
        do_op(mk_write(6'd11, 8'hDE), 16);
        do_op(mk_write(6'd10, 8'hAD), 16);
        // R6: frame after a write shifts zeros; read reg 5
        do_op(mk_read(6'd10, 8'hFF), 16);
        // R9: back-to-back reads
        do_op(mk_read(6'd63, 8'h00), 16);
        do_op(mk_read(6'd0, 8'h00), 16);
        // R8: short, long and bit-14 frames leave pending data alone
        do_op(mk_write(6'd0, 8'h55), 9);
        do_op(mk_write(6'd0, 8'h55), 19);
        do_op(16'hC000 | mk_write(6'd1, 8'h77), 16);
        do_op(mk_read(6'd2, 8'h00), 16);

        // R1: SCLK and DIN toggling while deselected are ignored
        begin
            int wc0;
            wc0 = wr_count;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk) sclk = ~sclk;
                mosi = 1'($urandom);
                chk(miso_oe == 1'b0, "R1 oe while deselected", {31'h0, miso_oe}, 32'h0);
            end
            sclk = 1'b0;
            repeat (GAP) @(negedge clk);
            chk(wr_count == wc0, "R1 no write while deselected", wr_count, wc0);
        end
        do_op(mk_read(6'd2, 8'h00), 16);

        for (int f = 0; f < 80; f++) begin
            int kind;
            logic [5:0] a;
            logic [7:0] d;
            kind = int'($urandom % 10);
            a = 6'($urandom);
            d = 8'($urandom);
            case (kind)
                0:       do_op(($urandom % 2) ? mk_write(a, d) : mk_read(a, d), 1 + int'($urandom % 15));
                1:       do_op(($urandom % 2) ? mk_write(a, d) : mk_read(a, d), 17 + int'($urandom % 4));
                2:       do_op(16'h4000 | mk_write(a, d), 16);
                3, 4, 5: do_op(mk_write(a, d), 16);
                default: do_op(mk_read(a, d), 16);
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule